// File: doc/BRIEF.md
# Bundle-Parallel Predicated Register File

This block is the integer register file of a three-slot VLIW core. Every cycle one bundle arrives. Each slot of the bundle carries one operation. That operation reads two source registers and may write one destination register. A predicate guards each write. The file holds 128 general registers of 64 bits and 64 one-bit predicate registers. The predicates are loaded through a dedicated single-bit write port, which serves the result of compare and test operations.

When several slots of one bundle touch the same register, a static mode input sets how they interact. In read-old mode every read returns the value held before the bundle, so two slots can exchange two registers in a single bundle. In read-new mode a read returns the data that another slot of the same bundle commits to that register. In forbidden mode a bundle in which one slot writes a register that another slot reads is illegal. In every mode the block raises a conflict flag for an illegal bundle and drops all of its general-register writes.

Top module: `vrf_bundle_regfile`

## Requirements
- R1: All read ports are combinational. A read of register 0 returns zero. A general write commits on the rising clock edge when its slot's enable is 1, its destination is not 0, its predicate is 1 and the bundle shows no conflict.
- R2: Each slot's 6-bit guard index selects one of 64 predicate bits. Guard index 0 always counts as true.
- R3: The predicate port writes one bit on the rising edge. Reset, synchronous and active high, clears predicates 1 to 63 to 0. A predicate write to index 0 has no effect. A write guard reads the predicate value held before the current bundle. The conflict flag does not block predicate writes.
- R4: Writes to register 0 are ignored. A write to register 0 never counts toward a conflict.
- R5: The mode input is encoded 0 for read-old, 1 for read-new, 2 for forbidden and 3 for a spare code. In read-old mode every read returns the pre-bundle value, and a two-slot swap in one bundle exchanges the two registers.
- R6: In read-new mode, a read whose address matches a write that another slot commits in the same bundle returns that write's data in the same cycle. A slot never sees its own write.
- R7: In read-new mode, a write whose predicate is 0 is not forwarded. The reader gets the old value.
- R8: In forbidden mode, the conflict flag rises in the same cycle when any slot writes a nonzero register that a different slot reads on either port. All general writes of that bundle are dropped. A slot that reads its own destination does not cause a conflict.
- R9: In every mode, if two slots enable writes to the same nonzero register, the conflict flag rises and all general writes of that bundle are dropped. No forwarding takes place in that bundle.
- R10: The spare mode code 3 behaves exactly like read-old.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Intra-bundle read/write mode (0 old, 1 new, 2 forbidden, 3 as old) |
| rd_addr_i | input | 3x2x7 | Source register index per slot and port |
| rd_data_o | output | 3x2x64 | Source data per slot and port |
| wr_en_i | input | 3 | Write enable per slot |
| wr_addr_i | input | 3x7 | Destination index per slot |
| wr_data_i | input | 3x64 | Write data per slot |
| wr_pred_i | input | 3x6 | Guard predicate index per slot |
| pw_en_i | input | 1 | Predicate write enable |
| pw_addr_i | input | 6 | Predicate index to write |
| pw_val_i | input | 1 | Predicate bit to write |
| conflict_o | output | 1 | Illegal-bundle flag for the current bundle |

## Verification
Some properties are checked on every cycle: write-write collisions and forbidden-mode read-after-write collisions raise the flag, read-old and spare modes raise it only on write-write collisions, register 0 reads zero on every port, a committed write is forwarded in read-new mode, and guard index 0 always counts as true. Other behaviour shows only across bundles, so the bench scenarios are needed for it. That covers the register exchange, the dropping of writes in a conflicting bundle, a false predicate blocking both the commit and the forward, the one-bundle delay before a predicate write takes effect, and the reset value of the predicates.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam int VRF_SLOTS  = 3;
    localparam int VRF_RPORTS = 2;
    localparam int VRF_DW     = 64;
    localparam int VRF_NREG   = 128;
    localparam int VRF_NPRED  = 64;
    localparam int VRF_AW     = $clog2(VRF_NREG);
    localparam int VRF_PW     = $clog2(VRF_NPRED);

    typedef logic [VRF_AW-1:0] reg_idx_t;
    typedef logic [VRF_PW-1:0] pred_idx_t;
    typedef logic [VRF_DW-1:0] word_t;

    typedef enum logic [1:0] {
        MODE_READ_OLD = 2'd0,
        MODE_READ_NEW = 2'd1,
        MODE_FORBID   = 2'd2,
        MODE_SPARE    = 2'd3
    } bundle_mode_e;

    typedef struct packed {
        logic      en;
        reg_idx_t  dst;
        word_t     data;
        pred_idx_t guard;
    } wr_op_t;

    function automatic logic is_live_dst(input logic en, input reg_idx_t dst);
        return en && (dst != '0);
    endfunction

    function automatic bundle_mode_e decode_mode(input logic [1:0] raw);
        bundle_mode_e m;
        case (raw)
            2'd1:    m = MODE_READ_NEW;
            2'd2:    m = MODE_FORBID;
            default: m = MODE_READ_OLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vrf_pred_file.sv
module vrf_pred_file
    import vrf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pw_en,
    input  pred_idx_t                  pw_idx,
    input  logic                       pw_val,
    input  pred_idx_t [VRF_SLOTS-1:0]  guard_i,
    output logic      [VRF_SLOTS-1:0]  ok_o
);

    logic [VRF_NPRED-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (pw_en && (pw_idx != '0)) begin
            bits_q[pw_idx] <= pw_val;
        end
    end

    // Entry 0 is hard-wired true; its storage bit is never consulted.
    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_guard
        assign ok_o[s] = (guard_i[s] == '0) ? 1'b1 : bits_q[guard_i[s]];
    end

endmodule

// File: rtl/vrf_hazard_unit.sv
module vrf_hazard_unit
    import vrf_pkg::*;
(
    input  bundle_mode_e                             mode,
    input  wr_op_t   [VRF_SLOTS-1:0]                 ops,
    input  reg_idx_t [VRF_SLOTS-1:0][VRF_RPORTS-1:0] raddr,
    input  logic     [VRF_SLOTS-1:0]                 guard_ok,
    output logic                                     ww_hit,
    output logic                                     raw_hit,
    output logic                                     conflict,
    output logic     [VRF_SLOTS-1:0]                 commit
);

    // Two live destinations naming the same register.
    always_comb begin
        ww_hit = 1'b0;
        for (int i = 0; i < VRF_SLOTS; i++) begin
            for (int j = i + 1; j < VRF_SLOTS; j++) begin
                if (is_live_dst(ops[i].en, ops[i].dst) &&
                    is_live_dst(ops[j].en, ops[j].dst) &&
                    (ops[i].dst == ops[j].dst)) begin
                    ww_hit = 1'b1;
                end
            end
        end
    end

    // A live destination of one slot read by a different slot.
    always_comb begin
        raw_hit = 1'b0;
        for (int i = 0; i < VRF_SLOTS; i++) begin
            for (int j = 0; j < VRF_SLOTS; j++) begin
                for (int p = 0; p < VRF_RPORTS; p++) begin
                    if ((i != j) && is_live_dst(ops[i].en, ops[i].dst) &&
                        (raddr[j][p] == ops[i].dst)) begin
                        raw_hit = 1'b1;
                    end
                end
            end
        end
    end

    assign conflict = ww_hit || ((mode == MODE_FORBID) && raw_hit);

    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_commit
        assign commit[s] = is_live_dst(ops[s].en, ops[s].dst) && guard_ok[s] && !conflict;
    end

endmodule

// File: rtl/vrf_gpr_array.sv
module vrf_gpr_array
    import vrf_pkg::*;
(
    input  logic                                     clk,
    input  wr_op_t   [VRF_SLOTS-1:0]                 ops,
    input  logic     [VRF_SLOTS-1:0]                 commit,
    input  reg_idx_t [VRF_SLOTS-1:0][VRF_RPORTS-1:0] raddr,
    output word_t    [VRF_SLOTS-1:0][VRF_RPORTS-1:0] rdata
);

    word_t mem [VRF_NREG];

    // At most one slot commits a given index per bundle, so slot order is moot.
    always_ff @(posedge clk) begin
        for (int s = 0; s < VRF_SLOTS; s++) begin
            if (commit[s]) begin
                mem[ops[s].dst] <= ops[s].data;
            end
        end
    end

    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < VRF_RPORTS; p++) begin : g_port
            assign rdata[s][p] = (raddr[s][p] == '0) ? '0 : mem[raddr[s][p]];
        end
    end

endmodule

// File: rtl/vrf_read_bypass.sv
module vrf_read_bypass
    import vrf_pkg::*;
#(
    parameter int OWN_SLOT = 0
) (
    input  bundle_mode_e              mode,
    input  wr_op_t   [VRF_SLOTS-1:0]  ops,
    input  logic     [VRF_SLOTS-1:0]  commit,
    input  reg_idx_t                  raddr,
    input  word_t                     old_data,
    output word_t                     rd_data
);

    always_comb begin
        rd_data = old_data;
        if ((mode == MODE_READ_NEW) && (raddr != '0)) begin
            for (int i = 0; i < VRF_SLOTS; i++) begin
                if ((i != OWN_SLOT) && commit[i] && (ops[i].dst == raddr)) begin
                    rd_data = ops[i].data;
                end
            end
        end
    end

endmodule

// File: rtl/vrf_bundle_regfile.sv
module vrf_bundle_regfile
    import vrf_pkg::*;
(
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic [1:0]                                      mode_i,
    input  logic [VRF_SLOTS-1:0][VRF_RPORTS-1:0][VRF_AW-1:0] rd_addr_i,
    output logic [VRF_SLOTS-1:0][VRF_RPORTS-1:0][VRF_DW-1:0] rd_data_o,
    input  logic [VRF_SLOTS-1:0]                            wr_en_i,
    input  logic [VRF_SLOTS-1:0][VRF_AW-1:0]                wr_addr_i,
    input  logic [VRF_SLOTS-1:0][VRF_DW-1:0]                wr_data_i,
    input  logic [VRF_SLOTS-1:0][VRF_PW-1:0]                wr_pred_i,
    input  logic                                            pw_en_i,
    input  logic [VRF_PW-1:0]                               pw_addr_i,
    input  logic                                            pw_val_i,
    output logic                                            conflict_o
);

    bundle_mode_e                              mode;
    wr_op_t    [VRF_SLOTS-1:0]                 ops;
    pred_idx_t [VRF_SLOTS-1:0]                 guards;
    logic      [VRF_SLOTS-1:0]                 slot_ok;
    logic      [VRF_SLOTS-1:0]                 commit;
    logic                                      ww_hit;
    logic                                      raw_hit;
    reg_idx_t  [VRF_SLOTS-1:0][VRF_RPORTS-1:0] raddr;
    word_t     [VRF_SLOTS-1:0][VRF_RPORTS-1:0] old_data;

    assign mode = decode_mode(mode_i);

    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_ops
        assign ops[s].en    = wr_en_i[s];
        assign ops[s].dst   = wr_addr_i[s];
        assign ops[s].data  = wr_data_i[s];
        assign ops[s].guard = wr_pred_i[s];
        assign guards[s]    = ops[s].guard;
        for (genvar p = 0; p < VRF_RPORTS; p++) begin : g_ra
            assign raddr[s][p] = rd_addr_i[s][p];
        end
    end

    vrf_pred_file u_pred (
        .clk     (clk),
        .rst     (rst),
        .pw_en   (pw_en_i),
        .pw_idx  (pw_addr_i),
        .pw_val  (pw_val_i),
        .guard_i (guards),
        .ok_o    (slot_ok)
    );

    vrf_hazard_unit u_hazard (
        .mode     (mode),
        .ops      (ops),
        .raddr    (raddr),
        .guard_ok (slot_ok),
        .ww_hit   (ww_hit),
        .raw_hit  (raw_hit),
        .conflict (conflict_o),
        .commit   (commit)
    );

    vrf_gpr_array u_gpr (
        .clk    (clk),
        .ops    (ops),
        .commit (commit),
        .raddr  (raddr),
        .rdata  (old_data)
    );

    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_byp_slot
        for (genvar p = 0; p < VRF_RPORTS; p++) begin : g_byp_port
            vrf_read_bypass #(.OWN_SLOT(s)) u_byp (
                .mode     (mode),
                .ops      (ops),
                .commit   (commit),
                .raddr    (raddr[s][p]),
                .old_data (old_data[s][p]),
                .rd_data  (rd_data_o[s][p])
            );
        end
    end

endmodule

// File: rtl/vrf_bundle_regfile_chk.sv
module vrf_bundle_regfile_chk
    import vrf_pkg::*;
(
    input logic                                            clk,
    input logic                                            rst,
    input logic [1:0]                                      mode_i,
    input logic [VRF_SLOTS-1:0][VRF_RPORTS-1:0][VRF_AW-1:0] rd_addr_i,
    input logic [VRF_SLOTS-1:0][VRF_RPORTS-1:0][VRF_DW-1:0] rd_data_o,
    input logic [VRF_SLOTS-1:0]                            wr_en_i,
    input logic [VRF_SLOTS-1:0][VRF_AW-1:0]                wr_addr_i,
    input logic [VRF_SLOTS-1:0][VRF_DW-1:0]                wr_data_i,
    input logic [VRF_SLOTS-1:0][VRF_PW-1:0]                wr_pred_i,
    input logic [VRF_SLOTS-1:0]                            slot_ok,
    input logic                                            conflict_o
);

    logic same_dst;
    logic cross_read;

    always_comb begin
        same_dst   = 1'b0;
        cross_read = 1'b0;
        for (int a = 0; a < VRF_SLOTS; a++) begin
            for (int b = 0; b < VRF_SLOTS; b++) begin
                if (a != b && wr_en_i[a] && wr_addr_i[a] != '0) begin
                    if (wr_en_i[b] && wr_addr_i[b] == wr_addr_i[a]) same_dst = 1'b1;
                    for (int p = 0; p < VRF_RPORTS; p++) begin
                        if (rd_addr_i[b][p] == wr_addr_i[a]) cross_read = 1'b1;
                    end
                end
            end
        end
    end

    assert_ww_conflict_R9: assert property (@(posedge clk) disable iff (rst)
        same_dst |-> conflict_o);

    assert_forbid_conflict_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2 && cross_read) |-> conflict_o);

    assert_old_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == 2'd0 || mode_i == 2'd3) && !same_dst) |-> !conflict_o);

    assert_forward_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && !conflict_o && wr_en_i[0] && slot_ok[0] &&
         wr_addr_i[0] != '0 && rd_addr_i[1][0] == wr_addr_i[0])
        |-> (rd_data_o[1][0] == wr_data_i[0]));

    assert_guard_zero_true_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_pred_i[2] == '0) |-> slot_ok[2]);

    for (genvar s = 0; s < VRF_SLOTS; s++) begin : g_zero
        for (genvar p = 0; p < VRF_RPORTS; p++) begin : g_port
            assert_zero_read_R1: assert property (@(posedge clk) disable iff (rst)
                (rd_addr_i[s][p] == '0) |-> (rd_data_o[s][p] == '0));
        end
    end

endmodule

bind vrf_bundle_regfile vrf_bundle_regfile_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_pred_i  (wr_pred_i),
    .slot_ok    (slot_ok),
    .conflict_o (conflict_o)
);

// File: tb/vrf_bundle_regfile_tb_top.sv
module vrf_bundle_regfile_tb_top;

    typedef struct {
        string       req;
        bit          is_conf;
        int          s;
        int          p;
        logic [63:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]            mode;
    logic [2:0][1:0][6:0]  rda;
    logic [2:0][1:0][63:0] rdd;
    logic [2:0]            we;
    logic [2:0][6:0]       wa;
    logic [2:0][63:0]      wd;
    logic [2:0][5:0]       wp;
    logic                  pwe;
    logic [5:0]            pwa;
    logic                  pwv;
    logic                  conf;

    // staging copies, applied to the DUT at the next falling edge
    logic [1:0]            s_mode;
    logic [2:0][1:0][6:0]  s_rda;
    logic [2:0]            s_we;
    logic [2:0][6:0]       s_wa;
    logic [2:0][63:0]      s_wd;
    logic [2:0][5:0]       s_wp;
    logic                  s_pwe;
    logic [5:0]            s_pwa;
    logic                  s_pwv;

    logic [63:0] gm [128];
    bit          pm [64];
    item_t       sb [$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    event        ev;

    vrf_bundle_regfile dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .rd_addr_i(rda), .rd_data_o(rdd),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .wr_pred_i(wp),
        .pw_en_i(pwe), .pw_addr_i(pwa), .pw_val_i(pwv), .conflict_o(conf)
    );

    function automatic logic [63:0] val(input int k);
        return 64'h5A00_0000_0000_0000 + 64'(k) * 64'h0001_0203_0405_0607;
    endfunction

    task automatic idle(input logic [1:0] m);
        s_mode = m; s_we = '0; s_wa = '0; s_wd = '0; s_wp = '0;
        s_pwe = 1'b0; s_pwa = '0; s_pwv = 1'b0;
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 2; p++) s_rda[s][p] = 7'(20 + s * 2 + p);
    endtask

    task automatic set_w(input int s, input logic [6:0] a, input logic [63:0] d, input logic [5:0] g);
        s_we[s] = 1'b1; s_wa[s] = a; s_wd[s] = d; s_wp[s] = g;
    endtask

    // Driver: apply a bundle, predict outputs from the requirements, then update the model.
    task automatic run(input string req);
        bit          c;
        bit [2:0]    cm;
        logic [63:0] e;
        @(negedge clk);
        mode = s_mode; rda = s_rda; we = s_we; wa = s_wa; wd = s_wd; wp = s_wp;
        pwe = s_pwe; pwa = s_pwa; pwv = s_pwv;
        #1;
        c = 0;
        for (int i = 0; i < 3; i++) begin
            if (we[i] && wa[i] != 0) begin
                for (int j = 0; j < 3; j++) begin
                    if (j != i && we[j] && wa[j] == wa[i]) c = 1;
                    if (j != i && mode == 2'd2 && (rda[j][0] == wa[i] || rda[j][1] == wa[i])) c = 1;
                end
            end
        end
        for (int i = 0; i < 3; i++)
            cm[i] = we[i] && wa[i] != 0 && (wp[i] == 0 || pm[wp[i]]) && !c;
        sb.push_back('{req, 1'b1, 0, 0, {63'd0, c}});
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 2; p++) begin
                e = (rda[s][p] == 0) ? 64'd0 : gm[rda[s][p]];
                if (mode == 2'd1 && rda[s][p] != 0)
                    for (int i = 0; i < 3; i++)
                        if (i != s && cm[i] && wa[i] == rda[s][p]) e = wd[i];
                sb.push_back('{req, 1'b0, s, p, e});
            end
        end
        -> ev;
        @(posedge clk);
        for (int i = 0; i < 3; i++) if (cm[i]) gm[wa[i]] = wd[i];
        if (pwe && pwa != 0) pm[pwa] = pwv;
    endtask

    // Monitor: pop predicted items and compare with what the design shows.
    initial begin
        item_t       it;
        logic [63:0] act;
        forever begin
            @(ev);
            while (sb.size() > 0) begin
                it = sb.pop_front();
                act = it.is_conf ? {63'd0, conf} : rdd[it.s][it.p];
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    if (it.is_conf)
                        $display("FAIL %s conflict: actual %0h expected %0h", it.req, act, it.exp);
                    else
                        $display("FAIL %s read slot%0d port%0d: actual %h expected %h",
                                 it.req, it.s, it.p, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 128; k++) gm[k] = 64'd0;
        for (int k = 0; k < 64; k++) pm[k] = 1'b0;
        idle(2'd0);
        mode = s_mode; rda = '0; we = '0; wa = '0; wd = '0; wp = '0;
        pwe = 1'b0; pwa = '0; pwv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: loading registers with guard 0; all reads point at register 0
        idle(2'd0); s_rda = '0;
        set_w(0, 7'd1, val(1), 6'd0); set_w(1, 7'd2, val(2), 6'd0); set_w(2, 7'd3, val(3), 6'd0);
        run("R1");
        idle(2'd0); s_rda = '0;
        set_w(0, 7'd4, val(4), 6'd0); set_w(1, 7'd5, val(5), 6'd0); set_w(2, 7'd6, val(6), 6'd0);
        run("R1");
        idle(2'd0); s_rda = '0;
        set_w(0, 7'd20, val(20), 6'd0); set_w(1, 7'd21, val(21), 6'd0); set_w(2, 7'd22, val(22), 6'd0);
        run("R1");
        idle(2'd0); s_rda = '0;
        set_w(0, 7'd23, val(23), 6'd0); set_w(1, 7'd24, val(24), 6'd0); set_w(2, 7'd25, val(25), 6'd0);
        run("R1");
        idle(2'd0); s_rda = '0;
        set_w(1, 7'd7, val(7), 6'd0);
        run("R1");

        // R3: predicate 5 cleared by reset -> write to r7 blocked
        idle(2'd0); set_w(0, 7'd7, val(77), 6'd5); s_rda[2][1] = 7'd7;
        run("R3");
        // R3: set predicate 5; guard in this same bundle still sees 0
        idle(2'd0); set_w(0, 7'd7, val(78), 6'd5); s_pwe = 1; s_pwa = 6'd5; s_pwv = 1;
        run("R3");
        idle(2'd0); set_w(1, 7'd7, val(79), 6'd5); s_rda[0][0] = 7'd7;
        run("R3");
        idle(2'd0); s_rda[2][0] = 7'd7;
        run("R3");

        // R5: swap r1 and r2 in one bundle in read-old mode
        idle(2'd0); s_rda[0][0] = 7'd2; s_rda[1][0] = 7'd1;
        set_w(0, 7'd1, gm[2], 6'd0); set_w(1, 7'd2, gm[1], 6'd0);
        run("R5");
        idle(2'd0); s_rda[0][0] = 7'd1; s_rda[1][1] = 7'd2;
        run("R5");

        // R6: read-new forwarding to other slots, not to the writer itself
        idle(2'd1); set_w(0, 7'd3, val(33), 6'd0);
        s_rda[0][1] = 7'd3; s_rda[1][0] = 7'd3; s_rda[2][1] = 7'd3;
        run("R6");

        // R7: false predicate 9 -> no forward, no commit; predicate set in same bundle
        idle(2'd1); set_w(2, 7'd4, val(44), 6'd9); s_rda[0][0] = 7'd4;
        s_pwe = 1; s_pwa = 6'd9; s_pwv = 1;
        run("R7");
        idle(2'd1); set_w(2, 7'd4, val(45), 6'd9); s_rda[0][0] = 7'd4; s_rda[1][1] = 7'd4;
        run("R7");

        // R8: forbidden mode, cross-slot read of a written register
        idle(2'd2); set_w(0, 7'd5, val(55), 6'd0); set_w(1, 7'd6, val(66), 6'd0);
        s_rda[2][1] = 7'd5;
        run("R8");
        idle(2'd0); s_rda[0][0] = 7'd5; s_rda[1][0] = 7'd6;
        run("R8");
        // R8: writer reading its own destination is legal
        idle(2'd2); set_w(0, 7'd5, val(56), 6'd0); s_rda[0][0] = 7'd5;
        run("R8");
        idle(2'd2); s_rda[1][0] = 7'd5;
        run("R8");

        // R9: two slots writing r6, read-new and read-old modes
        idle(2'd1); set_w(0, 7'd6, val(61), 6'd0); set_w(2, 7'd6, val(62), 6'd0);
        s_rda[1][0] = 7'd6;
        run("R9");
        idle(2'd0); set_w(0, 7'd6, val(63), 6'd0); set_w(1, 7'd6, val(64), 6'd0);
        s_rda[2][0] = 7'd6;
        run("R9");
        idle(2'd0); s_rda[0][1] = 7'd6;
        run("R9");

        // R4: register 0 writes ignored and never conflict
        idle(2'd1); set_w(1, 7'd0, val(90), 6'd0); set_w(2, 7'd0, val(91), 6'd0);
        s_rda[0][0] = 7'd0;
        run("R4");
        idle(2'd2); set_w(0, 7'd0, val(92), 6'd0); s_rda[1][0] = 7'd0;
        run("R4");

        // R2: predicate index 0 cannot be cleared
        idle(2'd0); s_pwe = 1; s_pwa = 6'd0; s_pwv = 0;
        run("R2");
        idle(2'd0); set_w(2, 7'd1, val(101), 6'd0);
        run("R2");
        idle(2'd0); s_rda[1][1] = 7'd1;
        run("R2");

        // R10: spare mode code acts as read-old
        idle(2'd3); set_w(0, 7'd3, val(303), 6'd0); s_rda[1][0] = 7'd3; s_rda[2][0] = 7'd3;
        run("R10");
        idle(2'd3); s_rda[0][0] = 7'd3;
        run("R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule